// File: doc/BRIEF.md
# Sequenced Control Word Loader

This block programs one physical control register from a buffer of control words. A requester pulses `start`. The loader then writes each buffered word to the target in index order. After each write it reads the register back until the read is accepted, which proves that the write has taken effect. Only then does it move to the next word.

The default buffer has three setup words and one final word. Each setup word selects one oscillator rate code together with the matching single source enable. The final word enables all three sources and carries no rate code.

The target answers every access with OK, BUSY, WOULDBLOCK or a failure code.

- BUSY causes a retry after a fixed pause.
- WOULDBLOCK causes a retry after a pause equal to the tick count returned with the response.
- Both kinds of retry are counted separately and have their own limits. Reaching a limit aborts the sequence.
- A failure code aborts the sequence at once.
- At the end of the sequence, `done` pulses and `err` reports the outcome.

Top module: `cfgld_top`

## Requirements
- R1: After reset the loader is idle (`reqValid`, `done` low, `err` = 0). The buffer holds default words laid out as follows:
  - source enables in bits [2:0];
  - mode bit 4 = 1;
  - rate code in bits [9:8];
  - mux select in bits [13:12] = 2;
  - settle count in bits [31:16] = 2048.
  
  Setup word i (i = 0..2) has rate code i+1 and only enable bit i set. The last word has enables 3'b111 and rate code 0. The defaults are 0x08002111, 0x08002212, 0x08002314 and 0x08002017.
- R2: A `start` sampled while idle produces the first request in the next cycle. Words are written in index order 0 to NUM_WORDS-1, with `reqData` equal to the buffered word.
- R3: Each write (`reqWrite` = 1) is followed, after an OK response, by a read (`reqWrite` = 0) in the next cycle. The next word's write follows an OK read in the next cycle. Every request lasts one cycle.
- R4: An OK read of the last word makes `done` high for exactly one cycle, in the next cycle, with `err` = 0.
- R5: A BUSY response (rspCode 1) below the limit reissues the same access PAUSE_CYCLES+1 cycles after the response cycle.
- R6: A WOULDBLOCK response (rspCode 2) below the limit reissues the same access rspTicks+1 cycles after the response cycle. A tick count of 0 means the next cycle.
- R7: The BUSY_LIMIT-th BUSY response of a sequence aborts it with no retry. `done` pulses in the next cycle with `err` = 1.
- R8: The BLOCK_LIMIT-th WOULDBLOCK response of a sequence aborts it with `done` and `err` = 2.
- R9: A failure response (rspCode 3), in either the write or the read phase, aborts at once with `done` and `err` = 3.
- R10: Both retry counts are cleared at every accepted `start`, so retries from earlier sequences never count toward a limit.
- R11: `err` keeps its value after `done` until the next accepted `start`, and reads 0 from the cycle after that `start`.
- R12: `start` while a sequence is running is ignored; the request stream is unchanged.
- R13: A buffer write (`bufWe` with `bufAddr`, `bufData`) replaces that entry, and the next sequence sends the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load sequence (accepted only when idle) |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 2 | Outcome: 0 ok, 1 busy limit, 2 would-block limit, 3 no device |
| bufWe | input | 1 | Buffer entry write enable |
| bufAddr | input | IDX_W | Buffer entry index |
| bufData | input | 64 | Buffer entry value |
| reqValid | output | 1 | One-cycle access request to the target register |
| reqWrite | output | 1 | 1 = write, 0 = read-back |
| reqData | output | 64 | Word being written |
| rspValid | input | 1 | Target response strobe (one cycle, after the request) |
| rspCode | input | 2 | 0 OK, 1 BUSY, 2 WOULDBLOCK, 3 failure |
| rspTicks | input | TICK_W | Retry delay that accompanies a WOULDBLOCK |

## Verification
A wrong word index or read/write phase shows up at the ports as a wrong `reqData` or `reqWrite` on the very next request, one cycle after the response that caused it. A miscounted pause shows as a request that arrives one or more cycles early or late. A retry counter that is off, or one that was not cleared by `start`, does not show until a limit is reached: the abort comes one retry early or late, or a sequence that should succeed ends with `err` set. Checking `reqValid` and `done` in every cycle against a reference model exposes each of these in the first cycle where the two diverge.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int CW_W       = 64;
  localparam int SRC_EN_LSB = 0;
  localparam int MODE_BIT   = 4;
  localparam int VCO_LSB    = 8;
  localparam int MUX_LSB    = 12;
  localparam int SETTLE_LSB = 16;
  localparam int SETTLE_DEF = 2048;
  localparam int MUX_DEF    = 2;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_BUSY  = 2'd1,
    RSP_BLOCK = 2'd2,
    RSP_FAIL  = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_BUSY  = 2'd1,
    ERR_BLOCK = 2'd2,
    ERR_NODEV = 2'd3
  } err_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic clear;
    logic advance;
    logic bumpBusy;
    logic bumpBlock;
    logic loadShort;
    logic loadTicks;
    logic pauseRun;
    logic setErr;
    err_e errCode;
  } seq_stb_t;

  // setup words carry one rate code and one enable; the last enables all sources
  function automatic logic [CW_W-1:0] defaultWord(int idx, int lastIdx);
    logic [CW_W-1:0] w;
    w = (CW_W'(SETTLE_DEF) << SETTLE_LSB) | (CW_W'(MUX_DEF) << MUX_LSB) |
        (CW_W'(1) << MODE_BIT);
    if (idx < lastIdx)
      w = w | (CW_W'(idx + 1) << VCO_LSB) | (CW_W'(1) << (SRC_EN_LSB + idx));
    else
      w = w | (CW_W'(7) << SRC_EN_LSB);
    return w;
  endfunction
endpackage

// File: rtl/cfgld_dpath.sv
module cfgld_dpath
  import cfgld_pkg::*;
#(
  parameter int NUM_WORDS    = 4,
  parameter int BUSY_LIMIT   = 100,
  parameter int BLOCK_LIMIT  = 60000,
  parameter int PAUSE_CYCLES = 50,
  parameter int TICK_W       = 16,
  localparam int IDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_stb_t          stb,
  input  logic              bufWe,
  input  logic [IDX_W-1:0]  bufAddr,
  input  logic [CW_W-1:0]   bufData,
  input  logic [TICK_W-1:0] rspTicks,
  output logic [CW_W-1:0]   reqData,
  output logic              busyExhaust,
  output logic              blockExhaust,
  output logic              lastWord,
  output logic              pauseLast,
  output err_e              errCode
);
  timeunit 1ns; timeprecision 100ps;

  localparam int BCW    = $clog2(BUSY_LIMIT + 1);
  localparam int KCW    = $clog2(BLOCK_LIMIT + 1);
  localparam int PSHORT = $clog2(PAUSE_CYCLES + 1);
  localparam int PSW    = (TICK_W > PSHORT) ? TICK_W : PSHORT;

  logic [CW_W-1:0]  words [NUM_WORDS];
  logic [IDX_W-1:0] wordIdx;
  logic [BCW-1:0]   busyCnt;
  logic [KCW-1:0]   blockCnt;
  logic [PSW-1:0]   pauseCnt;

  // word buffer, reset to the example configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= defaultWord(i, NUM_WORDS - 1);
    end else if (bufWe) begin
      words[bufAddr] <= bufData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      busyCnt  <= '0;
      blockCnt <= '0;
      errCode  <= ERR_NONE;
    end else if (stb.clear) begin
      wordIdx  <= '0;
      busyCnt  <= '0;
      blockCnt <= '0;
      errCode  <= ERR_NONE;
    end else begin
      if (stb.advance)   wordIdx  <= wordIdx + 1'b1;
      if (stb.bumpBusy)  busyCnt  <= busyCnt + 1'b1;
      if (stb.bumpBlock) blockCnt <= blockCnt + 1'b1;
      if (stb.setErr)    errCode  <= stb.errCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pauseCnt <= '0;
    else if (stb.loadShort) pauseCnt <= PSW'(PAUSE_CYCLES);
    else if (stb.loadTicks) pauseCnt <= PSW'(rspTicks);
    else if (stb.pauseRun)  pauseCnt <= pauseCnt - 1'b1;
  end

  assign reqData      = words[wordIdx];
  assign busyExhaust  = (busyCnt == BCW'(BUSY_LIMIT - 1));
  assign blockExhaust = (blockCnt == KCW'(BLOCK_LIMIT - 1));
  assign lastWord     = (wordIdx == IDX_W'(NUM_WORDS - 1));
  assign pauseLast    = (pauseCnt == PSW'(1));

  // R7
  busy_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BCW'(BUSY_LIMIT - 1));
  // R8
  block_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockCnt <= KCW'(BLOCK_LIMIT - 1));
  // R2
  advance_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> !lastWord);
  // R5
  pause_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pauseRun |-> pauseCnt != '0);
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rspValid,
  input  logic [1:0] rspCode,
  input  logic       ticksZero,
  input  logic       busyExhaust,
  input  logic       blockExhaust,
  input  logic       lastWord,
  input  logic       pauseLast,
  output seq_stb_t   stb,
  output logic       reqValid,
  output logic       reqWrite,
  output logic       done
);
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PAUSE} state_e;

  state_e state, stateNext;
  logic   readPhase, readPhaseNext, doneNext;

  always_comb begin
    stb           = '0;
    stateNext     = state;
    readPhaseNext = readPhase;
    doneNext      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.clear     = 1'b1;
          readPhaseNext = 1'b0;
          stateNext     = S_ISSUE;
        end
      end
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT: begin
        if (rspValid) begin
          unique case (rsp_e'(rspCode))
            RSP_OK: begin
              if (!readPhase) begin
                readPhaseNext = 1'b1;
                stateNext     = S_ISSUE;
              end else if (lastWord) begin
                doneNext  = 1'b1;
                stateNext = S_IDLE;
              end else begin
                stb.advance   = 1'b1;
                readPhaseNext = 1'b0;
                stateNext     = S_ISSUE;
              end
            end
            RSP_BUSY: begin
              if (busyExhaust) begin
                stb.setErr  = 1'b1;
                stb.errCode = ERR_BUSY;
                doneNext    = 1'b1;
                stateNext   = S_IDLE;
              end else begin
                stb.bumpBusy  = 1'b1;
                stb.loadShort = 1'b1;
                stateNext     = S_PAUSE;
              end
            end
            RSP_BLOCK: begin
              if (blockExhaust) begin
                stb.setErr  = 1'b1;
                stb.errCode = ERR_BLOCK;
                doneNext    = 1'b1;
                stateNext   = S_IDLE;
              end else begin
                stb.bumpBlock = 1'b1;
                stb.loadTicks = !ticksZero;
                stateNext     = ticksZero ? S_ISSUE : S_PAUSE;
              end
            end
            default: begin
              stb.setErr  = 1'b1;
              stb.errCode = ERR_NODEV;
              doneNext    = 1'b1;
              stateNext   = S_IDLE;
            end
          endcase
        end
      end
      S_PAUSE: begin
        stb.pauseRun = 1'b1;
        if (pauseLast) stateNext = S_ISSUE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      readPhase <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= stateNext;
      readPhase <= readPhaseNext;
      done      <= doneNext;
    end
  end

  assign reqValid = (state == S_ISSUE);
  assign reqWrite = !readPhase;

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int NUM_WORDS    = 4,
  parameter int BUSY_LIMIT   = 100,
  parameter int BLOCK_LIMIT  = 60000,
  parameter int PAUSE_CYCLES = 50,
  parameter int TICK_W       = 16,
  localparam int IDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic [1:0]        err,
  input  logic              bufWe,
  input  logic [IDX_W-1:0]  bufAddr,
  input  logic [63:0]       bufData,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [63:0]       reqData,
  input  logic              rspValid,
  input  logic [1:0]        rspCode,
  input  logic [TICK_W-1:0] rspTicks
);
  timeunit 1ns; timeprecision 100ps;

  seq_stb_t stb;
  logic     busyExhaust, blockExhaust, lastWord, pauseLast;
  err_e     errCode;

  cfgld_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rspValid(rspValid), .rspCode(rspCode),
    .ticksZero(rspTicks == '0), .busyExhaust(busyExhaust), .blockExhaust(blockExhaust),
    .lastWord(lastWord), .pauseLast(pauseLast), .stb(stb), .reqValid(reqValid),
    .reqWrite(reqWrite), .done(done)
  );

  cfgld_dpath #(
    .NUM_WORDS(NUM_WORDS), .BUSY_LIMIT(BUSY_LIMIT), .BLOCK_LIMIT(BLOCK_LIMIT),
    .PAUSE_CYCLES(PAUSE_CYCLES), .TICK_W(TICK_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .bufWe(bufWe), .bufAddr(bufAddr),
    .bufData(bufData), .rspTicks(rspTicks), .reqData(reqData),
    .busyExhaust(busyExhaust), .blockExhaust(blockExhaust), .lastWord(lastWord),
    .pauseLast(pauseLast), .errCode(errCode)
  );

  assign err = errCode;

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (err != 2'd0 && !start) |=> $stable(err));
endmodule

// File: tb/test_cfgld_top.sv
module test_cfgld_top;
  timeunit 1ns; timeprecision 100ps;

  localparam int BL = 4, KL = 5, SD = 3, LAT = 2;

  logic        clk = 1'b0;
  logic        rstN, start, bufWe, rspValid;
  logic [1:0]  bufAddr, rspCode, err;
  logic [63:0] bufData, reqData;
  logic [15:0] rspTicks;
  logic        done, reqValid, reqWrite;

  always #2.5 clk = ~clk;

  cfgld_top #(.NUM_WORDS(4), .BUSY_LIMIT(BL), .BLOCK_LIMIT(KL),
              .PAUSE_CYCLES(SD), .TICK_W(16)) i_cfgld_top (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .err(err),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqData(reqData),
    .rspValid(rspValid), .rspCode(rspCode), .rspTicks(rspTicks)
  );

  int checks = 0, fails = 0;
  logic [63:0] expWords [4];
  int qCode[$];
  int qTicks[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int t);
    qCode.push_back(c);
    qTicks.push_back(t);
  endtask

  task automatic loadWord(input int a, input logic [63:0] d);
    @(negedge clk);
    bufWe = 1'b1; bufAddr = 2'(a); bufData = d;
    @(negedge clk);
    bufWe = 1'b0;
    expWords[a] = d;
  endtask

  // behavioural target plus expected-stream model, compared every cycle
  task automatic runSeq(input string dataTag, input string errTag, input int expErr,
                        input int stray);
    int cyc = 0, expReqAt = 1, rspAt = -1, doneAt = -1;
    int phase = 0, idx = 0, busyN = 0, blkN = 0, mErr = 0;
    string reqTag = "R2";
    bit fin = 0;
    @(negedge clk);
    start = 1'b1;
    while (!fin && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      start    = (stray != 0 && cyc == stray);
      rspValid = 1'b0;
      if (cyc == 1) chk(err == 2'd0, "R11", "err cleared after start", 64'(err), 0);
      chk(reqValid === (cyc == expReqAt),
          (stray != 0 && cyc == stray + 1) ? "R12" : reqTag, "reqValid timing",
          64'(reqValid), 64'(cyc == expReqAt));
      if (reqValid && cyc == expReqAt) begin
        chk(reqWrite === (phase == 0), "R3", "reqWrite phase", 64'(reqWrite), 64'(phase == 0));
        if (phase == 0) chk(reqData === expWords[idx], dataTag, "written word", reqData, expWords[idx]);
        rspAt = cyc + LAT;
      end
      chk(done === (cyc == doneAt), (cyc == doneAt) ? errTag : "R4", "done pulse",
          64'(done), 64'(cyc == doneAt));
      if (cyc == doneAt) begin
        chk(err == 2'(mErr), errTag, "err code", 64'(err), 64'(mErr));
        fin = 1;
      end
      if (cyc == rspAt) begin
        int c, t;
        c = (qCode.size() != 0) ? qCode.pop_front() : 0;
        t = (qTicks.size() != 0) ? qTicks.pop_front() : 0;
        rspValid = 1'b1; rspCode = 2'(c); rspTicks = 16'(t);
        case (c)
          0: begin
            reqTag = "R3";
            if (phase == 0) begin phase = 1; expReqAt = cyc + 1; end
            else if (idx == 3) doneAt = cyc + 1;
            else begin idx++; phase = 0; expReqAt = cyc + 1; reqTag = "R2"; end
          end
          1: begin
            busyN++; reqTag = "R5";
            if (busyN >= BL) begin mErr = 1; doneAt = cyc + 1; end
            else expReqAt = cyc + 1 + SD;
          end
          2: begin
            blkN++; reqTag = "R6";
            if (blkN >= KL) begin mErr = 2; doneAt = cyc + 1; end
            else expReqAt = cyc + 1 + t;
          end
          default: begin mErr = 3; doneAt = cyc + 1; end
        endcase
      end
    end
    chk(fin, errTag, "sequence ended", 64'(fin), 1);
    start = 1'b0; rspValid = 1'b0;
    qCode.delete(); qTicks.delete();
    if (expErr != mErr) chk(0, errTag, "model outcome", 64'(mErr), 64'(expErr));
    // R11: outcome held while idle, no stray activity
    repeat (4) begin
      @(negedge clk);
      chk(err == 2'(expErr) && !done && !reqValid, "R11", "idle hold",
          {61'd0, err, done}, 64'(expErr) << 1);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; bufWe = 1'b0; bufAddr = '0; bufData = '0;
    rspValid = 1'b0; rspCode = '0; rspTicks = '0;
    expWords[0] = 64'h0800_2111; expWords[1] = 64'h0800_2212;
    expWords[2] = 64'h0800_2314; expWords[3] = 64'h0800_2017;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!reqValid && !done && err == 2'd0, "R1", "reset outputs",
        {61'd0, reqValid, done, err[0]}, 0);

    // R1 defaults sent in order, all OK
    runSeq("R1", "R4", 0, 0);

    // R13 new words; R5 R6 retries; R12 stray start
    loadWord(0, 64'hA5A5_0000_1111_0001);
    loadWord(2, 64'h5A5A_FFFF_0000_0004);
    push(1, 0); push(0, 0); push(2, 0); push(0, 0);
    push(0, 0); push(2, 7); push(0, 0);
    runSeq("R13", "R4", 0, 3);

    // R10 three BUSY below the limit must still succeed
    push(1, 0); push(0, 0); push(1, 0); push(0, 0); push(0, 0); push(1, 0);
    runSeq("R2", "R10", 0, 0);

    // R7 busy limit reached
    push(0, 0); push(1, 0); push(1, 0); push(1, 0); push(1, 0);
    runSeq("R2", "R7", 1, 0);

    // R8 would-block limit reached
    for (int i = 0; i < KL; i++) push(2, 2);
    runSeq("R2", "R8", 2, 0);

    // R9 failure code during a read-back
    for (int i = 0; i < 5; i++) push(0, 0);
    push(3, 0);
    runSeq("R2", "R9", 3, 0);

    // R9 failure code during a write
    push(3, 0);
    runSeq("R2", "R9", 3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule